// File: doc/BRIEF.md
# Event Interrupt Status and Enable Registers

This block collects five single-cycle event pulses from the rest of a serial infrared controller and turns them into one level interrupt. The five sources are transmit done, receive done, transmit underrun, receive overflow and serial gap received. Each pulse sets a sticky bit in a byte-wide status register. Software clears a bit by writing a one to it. A second byte-wide register holds the enable mask.

The interrupt output is a registered level. It is high while any status bit whose enable bit is also set remains set. Both registers share a small byte register bus with writes and combinational reads. The status register is at `STAT_ADDR` and the enable register is at the next address.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every status and enable bit is 0 and `irq` is 0, so both registers read as 0x07.
- R2: A pulse on `evt_pulse[i]` sets status bit i+3, and the bit stays set after the pulse ends. The mapping is: bit 7 transmit done (`evt_pulse[4]`), bit 6 receive done, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap (`evt_pulse[0]`).
- R3: A write to the status register (address 0x0C by default) clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the enable register (the status address plus one, 0x0D by default) loads data bits 7..3 into the enable mask. The mask covering all sources is 0xF8.
- R6: Bits 2..0 of both registers always read as 1, whatever was written to them.
- R7: An event sets its status bit even while its enable bit is 0.
- R8: `irq` equals the OR over bits 7..3 of status AND enable, as they stood one clock earlier.
- R9: A write to any other address changes neither register, and a read from any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the byte bus |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| evt_pulse | input | 5 | Event pulses: [4] tx done, [3] rx done, [2] tx underrun, [1] rx overflow, [0] serial gap |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions check the following on every cycle:
- a pulse sets its status bit;
- a clearing write removes exactly the written ones, unless the same bit also has an event that cycle;
- the enable register loads bits 7..3;
- the low three read bits are ones;
- status holds when there is neither a write nor an event;
- `irq` tracks the masked OR one cycle late.

Only the bench scenarios can show the whole register values across longer sequences. These cover interleaved enables and clears, writes to unmapped addresses, the exact cycle on which `irq` rises, and the collision case ending with the bit set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int BYTE_W  = 8;
    localparam int PAD_W   = BYTE_W - NUM_SRC;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  logic     clr_we_i,
    input  src_vec_t clr_mask_i,
    output src_vec_t stat_o
);
    typedef struct packed {
        src_vec_t stat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // a new event outranks a clear of the same bit
            if (set_i[i])
                st_d.stat[i] = 1'b1;
            else if (clr_we_i && clr_mask_i[i])
                st_d.stat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we_i,
    input  src_vec_t wdata_i,
    output src_vec_t ena_o
);
    typedef struct packed {
        src_vec_t ena;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.ena = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_o = st_q.ena;
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t stat_i,
    input  src_vec_t ena_i,
    output logic     irq_o
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat_i & ena_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ENA_ADDR = STAT_ADDR + 1'b1;

    logic     hit_stat, hit_ena;
    src_vec_t stat_bits, ena_bits, wr_src;

    assign hit_stat = (reg_addr == STAT_ADDR);
    assign hit_ena  = (reg_addr == ENA_ADDR);
    assign wr_src   = reg_wdata[BYTE_W-1:PAD_W];

    evt_status_bank u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_pulse),
        .clr_we_i   (reg_wr && hit_stat),
        .clr_mask_i (wr_src),
        .stat_o     (stat_bits)
    );

    evt_enable_bank u_ena (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_wr && hit_ena),
        .wdata_i (wr_src),
        .ena_o   (ena_bits)
    );

    evt_irq_merge u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_bits),
        .ena_i  (ena_bits),
        .irq_o  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_stat)     reg_rdata = {stat_bits, {PAD_W{1'b1}}};
        else if (hit_ena) reg_rdata = {ena_bits, {PAD_W{1'b1}}};
    end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int              ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] ena,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] ENA_ADDR = STAT_ADDR + 1'b1;

    // R2 R4
    evt_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((stat & $past(evt_pulse)) == $past(evt_pulse)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STAT_ADDR && evt_pulse == '0)
        |=> (stat == ($past(stat) & ~$past(reg_wdata[BYTE_W-1:PAD_W]))));

    // R5
    ena_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ENA_ADDR) |=> (ena == $past(reg_wdata[BYTE_W-1:PAD_W])));

    // R6
    pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_ADDR || reg_addr == ENA_ADDR) |-> (reg_rdata[PAD_W-1:0] == '1));

    // R9
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == STAT_ADDR) && evt_pulse == '0) |=> $stable(stat));

    // R8
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat & ena))));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .stat      (stat_bits),
    .ena       (ena_bits),
    .irq       (irq)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
    localparam logic [4:0] SA = 5'h0C;
    localparam logic [4:0] EA = 5'h0D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] evt_pulse = '0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
    );

    // evt, wr, addr, wdata, exp status read, exp enable read, exp irq
    typedef struct packed {
        logic [4:0] evt;
        logic       wr;
        logic [4:0] addr;
        logic [7:0] wdata;
        logic [7:0] xs;
        logic [7:0] xe;
        logic       xi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'b10000, 1'b0, SA,    8'h00, 8'h87, 8'h07, 1'b0}, // R2 R7
        '{5'b00000, 1'b1, EA,    8'hC0, 8'h87, 8'hC7, 1'b1}, // R5 R8
        '{5'b00001, 1'b0, SA,    8'h00, 8'h8F, 8'hC7, 1'b1}, // R2
        '{5'b00000, 1'b1, SA,    8'h80, 8'h0F, 8'hC7, 1'b0}, // R3 R8
        '{5'b00000, 1'b1, EA,    8'h0F, 8'h0F, 8'h0F, 1'b1}, // R5 R6
        '{5'b01110, 1'b0, SA,    8'h00, 8'h7F, 8'h0F, 1'b1}, // R2
        '{5'b00000, 1'b1, SA,    8'h07, 8'h7F, 8'h0F, 1'b1}, // R3 R6
        '{5'b00000, 1'b1, SA,    8'hFF, 8'h07, 8'h0F, 1'b0}, // R3
        '{5'b00000, 1'b1, EA,    8'hFF, 8'h07, 8'hFF, 1'b0}, // R5
        '{5'b00100, 1'b0, SA,    8'h00, 8'h27, 8'hFF, 1'b1}, // R2 R8
        '{5'b00000, 1'b1, 5'h05, 8'hFF, 8'h27, 8'hFF, 1'b1}, // R9
        '{5'b00000, 1'b1, SA,    8'h20, 8'h07, 8'hFF, 1'b0}  // R3
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check8(req, reg_rdata, exp);
    endtask

    task automatic idle_cycle;
        @(negedge clk);
        reg_wr = 1'b0;
        evt_pulse = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        read_chk("R1 status", SA, 8'h07);
        read_chk("R1 enable", EA, 8'h07);
        check8("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_pulse = VECS[i].evt;
            reg_wr    = VECS[i].wr;
            reg_addr  = VECS[i].addr;
            reg_wdata = VECS[i].wdata;
            idle_cycle();
            @(negedge clk);
            read_chk($sformatf("R2/R3/R5 vec%0d status", i), SA, VECS[i].xs);
            read_chk($sformatf("R5/R6 vec%0d enable", i), EA, VECS[i].xe);
            check8($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, VECS[i].xi});
        end

        // R9 unmapped read returns zero
        read_chk("R9 unmapped read", 5'h05, 8'h00);

        // R4 collision: event and clear of same bit in one cycle
        @(negedge clk);
        evt_pulse = 5'b01000;
        reg_wr = 1'b1; reg_addr = SA; reg_wdata = 8'h40;
        idle_cycle();
        read_chk("R4 collision", SA, 8'h47);

        // R8 exact timing: irq lags status by one cycle
        reg_wr = 1'b1; reg_addr = SA; reg_wdata = 8'hF8;
        idle_cycle();
        @(negedge clk);
        check8("R8 irq low after clear", {7'd0, irq}, 8'h00);
        evt_pulse = 5'b00010;
        idle_cycle();
        read_chk("R2 overflow bit", SA, 8'h17);
        check8("R8 irq not yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check8("R8 irq risen", {7'd0, irq}, 8'h01);

        // R7 disabled source still latches, irq stays low
        reg_wr = 1'b1; reg_addr = EA; reg_wdata = 8'h00;
        idle_cycle();
        reg_wr = 1'b1; reg_addr = SA; reg_wdata = 8'hFF;
        idle_cycle();
        evt_pulse = 5'b10000;
        idle_cycle();
        @(negedge clk);
        read_chk("R7 disabled latch", SA, 8'h87);
        check8("R7 irq masked", {7'd0, irq}, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule